// File: doc/BRIEF.md
# Selectable Clock Output Divider

This block turns a free-running reference tick into a square-wave output whose rate comes from a small control register. The reference tick is a one-cycle enable on the system clock. It arrives once per half-period of the 32.768 kHz reference, and never on two cycles in a row. A synchronous prescaler counts these ticks. One of four counter taps drives the output, so the output always has a 50% duty cycle. With the default spacing of five bits between taps, the four codes give 32768 Hz, 1024 Hz, 32 Hz and 1 Hz.

Software sets the rate and the gate through one byte-wide register on a plain write-strobe register port. The read path is combinational. A change to the register first waits in the register. It reaches the output stage only while the output is low and on a cycle with no tick. After that, the output rises only on a genuine rising transition of the newly selected tap. An enable, disable or rate change therefore never shortens a high pulse and never creates an extra edge. The port carries no data stream, so every pin is a plain control or status pin.

Top module: `cko_divider`

## Requirements
- R1: After reset, the register reads 0x80 (gate off, rate code 0) and `clk_out` is low and stays low.
- R2: The register sits at address 0x0D. Bit 7 is the gate-off bit and bits 1:0 are the rate code. A read at that address returns exactly these two fields, and bits 6:2 always read 0 whatever was written to them.
- R3: A write to any other address changes nothing, and a read at any other address returns 0.
- R4: With the gate on and rate code k, each high phase and each low phase of `clk_out` lasts 2^(k*TAP_STEP) reference ticks. With the default TAP_STEP of 5, this gives 32768, 1024, 32 and 1 Hz from a 65.536 kHz tick.
- R5: While the applied setting has the gate-off bit set, `clk_out` is low.
- R6: `clk_out` changes only on a cycle where `ref_tick` is high. Every high pulse lasts exactly the half-period of the rate that was applied when the pulse began.
- R7: Setting the gate-off bit while `clk_out` is high lets the current high pulse finish at full length. The output then stays low.
- R8: A rate change made while `clk_out` is high takes effect only after the current pulse ends at the old width. The applied setting never changes while `clk_out` is high. The next high pulse has the new width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference half-period; never high on two consecutive cycles |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from `reg_addr` |
| clk_out | output | 1 | Divided, gated output clock |

## Verification
Read data is combinational, so the bench checks each read a fraction of a cycle after it drives the address, on the falling clock edge. A write appears on the read path from the next rising edge. A written setting reaches the output only after the current high pulse has ended and a tick-free cycle has passed. Once applied, it becomes visible at the next rising edge of the selected tap. For this reason the bench never measures the first pulse after a write as a steady-state pulse. It either skips that pulse or measures it against the width of the old rate. Pulse widths are counted in system-clock cycles between edges sampled on the falling edge. With a tick on every other cycle, a width of N ticks appears as exactly 2N cycles.

// File: rtl/cko_pkg.sv
package cko_pkg;
  localparam int unsigned CODE_W    = 2;
  localparam int unsigned NUM_RATES = 2 ** CODE_W;

  typedef struct packed {
    logic              off;
    logic [CODE_W-1:0] code;
  } cko_cfg_t;

  localparam cko_cfg_t CFG_RESET = '{off: 1'b1, code: '0};
endpackage

// File: rtl/cko_regfile.sv
module cko_regfile
  import cko_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output cko_cfg_t          cfg_q
);
  localparam int unsigned PAD_W = DATA_W - 1 - CODE_W;

  logic hit;
  assign hit = (addr == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (we && hit) begin
      cfg_q.off  <= wdata[DATA_W-1];
      cfg_q.code <= wdata[CODE_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) rdata = {cfg_q.off, {PAD_W{1'b0}}, cfg_q.code};
  end
endmodule

// File: rtl/cko_prescaler.sv
module cko_prescaler
  import cko_pkg::*;
#(
  parameter int unsigned TAP_STEP = 5,
  localparam int unsigned CNT_W   = (NUM_RATES - 1) * TAP_STEP + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  output logic [NUM_RATES-1:0] tap_q,
  output logic [NUM_RATES-1:0] tap_nx
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_nx;
  end

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_tap
    assign tap_q[g]  = cnt_q[g*TAP_STEP];
    assign tap_nx[g] = cnt_nx[g*TAP_STEP];
  end
endmodule

// File: rtl/cko_glitchless.sv
module cko_glitchless
  import cko_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [NUM_RATES-1:0] tap_q,
  input  logic [NUM_RATES-1:0] tap_nx,
  input  cko_cfg_t             req_cfg,
  output cko_cfg_t             act_cfg,
  output logic                 out_q
);
  logic sel_now;
  logic sel_next;
  logic out_d;

  assign sel_now  = tap_q[act_cfg.code];
  assign sel_next = tap_nx[act_cfg.code];
  // Rising needs a true tap rise; falling follows the tap at once.
  assign out_d    = !act_cfg.off && sel_next && (out_q || !sel_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cfg <= CFG_RESET;
      out_q   <= 1'b0;
    end else begin
      if (!out_q && !tick) act_cfg <= req_cfg;
      if (tick)            out_q   <= out_d;
    end
  end
endmodule

// File: rtl/cko_divider.sv
module cko_divider
  import cko_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h0D,
  parameter int unsigned TAP_STEP = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              clk_out
);
  cko_cfg_t             req_cfg;
  cko_cfg_t             act_cfg;
  logic [NUM_RATES-1:0] tap_q;
  logic [NUM_RATES-1:0] tap_nx;
  logic [CODE_W-1:0]    act_code;
  logic                 act_dis;

  assign act_code = act_cfg.code;
  assign act_dis  = act_cfg.off;

  cko_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg_q(req_cfg)
  );

  cko_prescaler #(.TAP_STEP(TAP_STEP)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .tap_q(tap_q), .tap_nx(tap_nx)
  );

  cko_glitchless u_sel (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .tap_q(tap_q), .tap_nx(tap_nx),
    .req_cfg(req_cfg), .act_cfg(act_cfg), .out_q(clk_out)
  );
endmodule

// File: rtl/cko_divider_chk.sv
module cko_divider_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h0D,
  parameter int unsigned TAP_STEP = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_tick,
  input logic              clk_out,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [1:0]        act_code,
  input logic              act_dis
);
  int unsigned hi_cnt;
  logic [1:0]  lat_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= 0;
      lat_code <= '0;
    end else if (!clk_out) begin
      hi_cnt   <= 0;
      lat_code <= act_code;
    end else if (ref_tick) begin
      hi_cnt <= hi_cnt + 1;
    end
  end

  // R5
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_dis |-> !clk_out);

  // R6
  tick_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> $stable(clk_out));

  // R6
  runt_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_out) |-> hi_cnt == (32'd1 << (lat_code * TAP_STEP)));

  // R8
  cfg_switch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_code) || !$stable(act_dis)) |-> !clk_out);

  // R2
  rdata_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == REG_ADDR) |-> reg_rdata[DATA_W-2:2] == '0);

  // R3
  rdata_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != REG_ADDR) |-> reg_rdata == '0);
endmodule

bind cko_divider cko_divider_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR), .TAP_STEP(TAP_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .clk_out(clk_out),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .act_code(act_code), .act_dis(act_dis)
);

// File: tb/cko_divider_tb.sv
`timescale 1ns/1ps
module cko_divider_tb;
  localparam int unsigned STEP = 3;
  localparam logic [7:0]  ADDR = 8'h0D;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       tick_run = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = ADDR;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       clk_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cko_divider #(.TAP_STEP(STEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .clk_out(clk_out)
  );

  // Tick on every other cycle, changed away from the rising edge.
  initial forever begin
    @(negedge clk);
    ref_tick = tick_run ? ~ref_tick : 1'b0;
  end

  // Vectors: written byte, expected read-back, expected half-period in ticks (0 = gated off)
  localparam logic [7:0] VW [8] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h7E, 8'h81, 8'h41, 8'hFD};
  localparam logic [7:0] VR [8] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h02, 8'h81, 8'h01, 8'h81};
  localparam int         VH [8] = '{1, 8, 64, 512, 64, 0, 8, 0};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = ADDR;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = ADDR;
  endtask

  task automatic wait_level(input logic lvl, input string req);
    int n = 0;
    while (clk_out !== lvl && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (clk_out !== lvl) check(req, 0, 1);
  endtask

  task automatic low_for(input int n, input string req);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_out !== 1'b0) highs++;
    end
    check(req, highs, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    int t0, hi, lo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick_run = 1'b1;

    // R1 reset state
    rd(ADDR, rv); check("R1 reset readback", rv, 8'h80);
    check("R1 output low", clk_out, 0);
    low_for(300, "R1 stays low");

    // R3 other address ignored
    wr(8'h0C, 8'h01);
    rd(ADDR, rv); check("R3 write elsewhere", rv, 8'h80);
    rd(8'h0C, rv); check("R3 read elsewhere", rv, 0);
    low_for(100, "R3 output untouched");

    // Vector walk: R2 readback, R4 widths, R5 gating
    for (int v = 0; v < 8; v++) begin
      wr(ADDR, VW[v]);
      rd(ADDR, rv); check("R2 readback", rv, VR[v]);
      if (VH[v] == 0) begin
        wait_level(1'b0, "R5 settle");
        repeat (4) @(negedge clk);
        low_for(2200, "R5 gated low");
      end else begin
        wait_level(1'b0, "R4 settle"); wait_level(1'b1, "R4 settle");
        wait_level(1'b0, "R4 settle"); wait_level(1'b1, "R4 rise");
        t0 = cyc;
        wait_level(1'b0, "R4 fall"); hi = cyc - t0; t0 = cyc;
        wait_level(1'b1, "R4 rise"); lo = cyc - t0;
        check("R4 high phase", hi, 2 * VH[v]);
        check("R4 low phase", lo, 2 * VH[v]);
      end
    end

    // R7 disable mid-pulse keeps the full pulse
    wr(ADDR, 8'h02);
    wait_level(1'b0, "R7 settle"); wait_level(1'b1, "R7 settle");
    wait_level(1'b0, "R7 settle"); wait_level(1'b1, "R7 rise");
    t0 = cyc;
    repeat (10) @(negedge clk);
    wr(ADDR, 8'h82);
    wait_level(1'b0, "R7 fall"); hi = cyc - t0;
    check("R7 final pulse full", hi, 128);
    low_for(1200, "R7 low after disable");

    // R8 rate change mid-pulse: old width finishes, then new width
    wr(ADDR, 8'h03);
    wait_level(1'b1, "R8 rise");
    t0 = cyc;
    repeat (20) @(negedge clk);
    wr(ADDR, 8'h01);
    wait_level(1'b0, "R8 fall"); hi = cyc - t0;
    check("R8 old pulse width", hi, 1024);
    wait_level(1'b1, "R8 rise new"); t0 = cyc;
    wait_level(1'b0, "R8 fall new"); hi = cyc - t0;
    check("R8 new pulse width", hi, 16);

    // R6 fastest rate: every high pulse is one tick
    wr(ADDR, 8'h00);
    wait_level(1'b0, "R6 settle"); wait_level(1'b1, "R6 settle");
    wait_level(1'b0, "R6 settle"); wait_level(1'b1, "R6 rise");
    t0 = cyc;
    wait_level(1'b0, "R6 fall"); hi = cyc - t0;
    check("R6 one-tick pulse", hi, 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule